// File: doc/BRIEF.md
# Daisy-Chained Serial ADC Result Collector

This block sits on the host side of a string of identical successive-approximation converters whose serial outputs are chained head to tail. On a start request it raises the convert-start line while the serial clock is idle high and the data input of the first device is held low. Holding the first device's data input low at that rising edge puts the chain into chained mode with an end-of-conversion flag. The controller then waits for the serial data line from the chain to go from low to high. That edge marks the end of conversion.

Once the flag has been seen, the controller produces the serial clock by dividing the system clock. The first falling clock edge consumes the flag bit. The next 18·N falling edges bring in the results. The device closest to the host arrives first, and each result comes MSB first. Every bit is taken at the moment the controller drives the clock low. Convert-start is held high for the whole read and released only after the last edge. A one-cycle valid strobe then presents all N results together.

If the flag never arrives, a timeout ends the attempt, pulses an error flag and drops convert-start.

Top module: `chain_adc_reader`

## Requirements
- R1: After reset and whenever idle, cnvStart is 0, sclk is 1, headDin is 0, and sampleValid and convErr are 0. sclk is 1 in every cycle in which cnvStart is 0.
- R2: A startReq while idle raises cnvStart on the next clock. At that rising edge sclk is 1 and headDin is 0.
- R3: cnvStart stays 1 from its rising edge until after the last falling edge of sclk. No falling edge of sclk occurs while cnvStart is 0.
- R4: A read that sees the low-to-high edge on sdi produces exactly SAMPLE_W·NUM_DEV+1 falling edges of sclk.
- R5: During a read, each low phase and each high phase of sclk lasts DIV_HALF system clocks, so successive falling edges are 2·DIV_HALF clocks apart.
- R6: The bit on sdi just before falling edge k (k = 2 … SAMPLE_W·NUM_DEV+1) is captured. The first SAMPLE_W captured bits form device NUM_DEV's result, MSB first, then device NUM_DEV−1, and so on. Device d (1 = farthest from the host) is placed at samples[(d−1)·SAMPLE_W +: SAMPLE_W].
- R7: sampleValid is a one-cycle pulse in the same cycle that cnvStart falls. samples changes only in a cycle where sampleValid is 1 and otherwise holds the previous result, including during a read.
- R8: If no low-to-high edge on sdi appears within TIMEOUT clocks of waiting, convErr pulses for one cycle in the cycle cnvStart falls. No sclk edge and no sampleValid follow.
- R9: startReq is ignored while a conversion or read is in progress. Only one rising edge of cnvStart occurs per attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to start a conversion (taken when idle) |
| sdi | input | 1 | Serial data from the last device in the chain |
| cnvStart | output | 1 | Convert-start line to all devices |
| sclk | output | 1 | Serial clock to all devices, idles high |
| headDin | output | 1 | Data input of the first device, held low |
| samples | output | SAMPLE_W·NUM_DEV | Collected results, device d at slice d−1 |
| sampleValid | output | 1 | One-cycle strobe marking new samples |
| convErr | output | 1 | One-cycle strobe when the end-of-conversion wait times out |

## Verification
The bench builds the block with NUM_DEV = 3, DIV_HALF = 2 and TIMEOUT = 40. With three devices, the middle device shows that the result order is not simply reversed. The divider is short enough to run many 55-edge reads, yet still has separate high and low phases whose lengths can be measured. The short timeout lets the bench reach the error path and then run a normal read straight after it. Conversion delays of zero and several cycles are used, along with all-ones, all-zeros and alternating result patterns.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT,
    ST_FINISH
  } rdState_t;

  typedef struct packed {
    logic clearSr;
    logic shiftEn;
    logic latchOut;
  } dpCtl_t;

endpackage

// File: rtl/chain_adc_ctrl.sv
module chain_adc_ctrl
  import chain_adc_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int SAMPLE_W = 18,
  parameter int DIV_HALF = 4,
  parameter int TIMEOUT  = 1000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   sdiRise,
  output logic   cnvStart,
  output logic   sclk,
  output logic   convErr,
  output dpCtl_t dpCtl
);

  localparam int EDGES = SAMPLE_W * NUM_DEV + 1;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam int PH_W  = $clog2(DIV_HALF + 1);
  localparam int TO_W  = $clog2(TIMEOUT + 1);
  localparam logic [EC_W-1:0] EDGE_LAST = EC_W'(EDGES);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(DIV_HALF - 1);
  localparam logic [TO_W-1:0] TO_LAST   = TO_W'(TIMEOUT - 1);

  rdState_t        state;
  logic            cnvR;
  logic            sclkR;
  logic            errR;
  logic [PH_W-1:0] phaseCnt;
  logic [EC_W-1:0] edgeCnt;
  logic [TO_W-1:0] toCnt;
  logic            phaseDone;

  assign phaseDone = (phaseCnt == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnvR     <= 1'b0;
      sclkR    <= 1'b1;
      errR     <= 1'b0;
      phaseCnt <= '0;
      edgeCnt  <= '0;
      toCnt    <= '0;
    end else begin
      errR <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclkR <= 1'b1;
          if (startReq) begin
            cnvR  <= 1'b1;
            toCnt <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (sdiRise) begin
            phaseCnt <= '0;
            edgeCnt  <= '0;
            state    <= ST_SHIFT;
          end else if (toCnt == TO_LAST) begin
            cnvR  <= 1'b0;
            errR  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            toCnt <= toCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (phaseDone) begin
            phaseCnt <= '0;
            if (sclkR) begin
              sclkR   <= 1'b0;
              edgeCnt <= edgeCnt + 1'b1;
            end else begin
              sclkR <= 1'b1;
              if (edgeCnt == EDGE_LAST) begin
                state <= ST_FINISH;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_FINISH: begin
          cnvR  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.clearSr  = (state == ST_IDLE) && startReq;
    dpCtl.shiftEn  = (state == ST_SHIFT) && phaseDone && sclkR && (edgeCnt != '0);
    dpCtl.latchOut = (state == ST_FINISH);
  end

  assign cnvStart = cnvR;
  assign sclk     = sclkR;
  assign convErr  = errR;

endmodule

// File: rtl/chain_adc_dp.sv
module chain_adc_dp
  import chain_adc_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int SAMPLE_W = 18
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sdi,
  input  dpCtl_t                      dpCtl,
  output logic                        sdiRise,
  output logic [SAMPLE_W*NUM_DEV-1:0] samples,
  output logic                        sampleValid
);

  localparam int TOT_W = SAMPLE_W * NUM_DEV;

  logic             sdiQ;
  logic [TOT_W-1:0] shiftReg;
  logic [TOT_W-1:0] samplesQ;
  logic             validQ;

  assign sdiRise = sdi && !sdiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiQ     <= 1'b1;
      shiftReg <= '0;
      samplesQ <= '0;
      validQ   <= 1'b0;
    end else begin
      sdiQ   <= sdi;
      validQ <= dpCtl.latchOut;
      if (dpCtl.clearSr) begin
        shiftReg <= '0;
      end else if (dpCtl.shiftEn) begin
        shiftReg <= {shiftReg[TOT_W-2:0], sdi};
      end
      if (dpCtl.latchOut) begin
        samplesQ <= shiftReg;
      end
    end
  end

  // Bits arrive farthest-from-host last, so device d lands in slice d-1.
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_slice
    assign samples[d*SAMPLE_W +: SAMPLE_W] = samplesQ[d*SAMPLE_W +: SAMPLE_W];
  end

  assign sampleValid = validQ;

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_adc_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int SAMPLE_W = 18,
  parameter int DIV_HALF = 4,
  parameter int TIMEOUT  = 1000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic                        sdi,
  output logic                        cnvStart,
  output logic                        sclk,
  output logic                        headDin,
  output logic [SAMPLE_W*NUM_DEV-1:0] samples,
  output logic                        sampleValid,
  output logic                        convErr
);

  dpCtl_t dpCtl;
  logic   sdiRise;

  chain_adc_ctrl #(
    .NUM_DEV(NUM_DEV), .SAMPLE_W(SAMPLE_W), .DIV_HALF(DIV_HALF), .TIMEOUT(TIMEOUT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdiRise(sdiRise),
    .cnvStart(cnvStart), .sclk(sclk), .convErr(convErr), .dpCtl(dpCtl)
  );

  chain_adc_dp #(
    .NUM_DEV(NUM_DEV), .SAMPLE_W(SAMPLE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .dpCtl(dpCtl),
    .sdiRise(sdiRise), .samples(samples), .sampleValid(sampleValid)
  );

  assign headDin = 1'b0;

endmodule

// File: rtl/chain_adc_chk.sv
module chain_adc_chk #(
  parameter int NUM_DEV  = 2,
  parameter int SAMPLE_W = 18,
  parameter int DIV_HALF = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cnvStart,
  input logic                        sclk,
  input logic                        headDin,
  input logic [SAMPLE_W*NUM_DEV-1:0] samples,
  input logic                        sampleValid,
  input logic                        convErr
);

  localparam int EDGES = SAMPLE_W * NUM_DEV + 1;

  logic        sclkQ;
  logic        cnvQ;
  logic [15:0] fallCnt;
  logic [15:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b1;
      cnvQ    <= 1'b0;
      fallCnt <= '0;
      lowRun  <= '0;
    end else begin
      sclkQ <= sclk;
      cnvQ  <= cnvStart;
      if (cnvStart && !cnvQ) fallCnt <= '0;
      else if (sclkQ && !sclk) fallCnt <= fallCnt + 1'b1;
      if (sclk) lowRun <= '0;
      else if (lowRun != 16'hFFFF) lowRun <= lowRun + 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN) !cnvStart |-> sclk); // R1
  AST_CNV_RISE_SAFE: assert property (@(posedge clk) disable iff (!rstN) $rose(cnvStart) |-> (sclk && !headDin)); // R2
  AST_NO_FALL_IDLE: assert property (@(posedge clk) disable iff (!rstN) $fell(sclk) |-> cnvStart); // R3
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rstN) sampleValid |-> (fallCnt == 16'(EDGES))); // R4
  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rstN) ($rose(sclk) && cnvStart) |-> (lowRun == 16'(DIV_HALF))); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) sampleValid |=> !sampleValid); // R7
  AST_VALID_AT_FALL: assert property (@(posedge clk) disable iff (!rstN) sampleValid |-> $fell(cnvStart)); // R7
  AST_SAMPLES_HOLD: assert property (@(posedge clk) disable iff (!rstN) !sampleValid |-> $stable(samples)); // R7
  AST_ERR_AT_FALL: assert property (@(posedge clk) disable iff (!rstN) convErr |-> ($fell(cnvStart) && !sampleValid)); // R8

endmodule

bind chain_adc_reader chain_adc_chk #(
  .NUM_DEV(NUM_DEV), .SAMPLE_W(SAMPLE_W), .DIV_HALF(DIV_HALF)
) i_chk (
  .clk(clk), .rstN(rstN), .cnvStart(cnvStart), .sclk(sclk), .headDin(headDin),
  .samples(samples), .sampleValid(sampleValid), .convErr(convErr)
);

// File: tb/test_chain_adc_reader.sv
`timescale 1ns/1ps
module test_chain_adc_reader;

  localparam int NUM_DEV  = 3;
  localparam int SAMPLE_W = 18;
  localparam int DIV_HALF = 2;
  localparam int TIMEOUT  = 40;
  localparam int TOT_W    = NUM_DEV * SAMPLE_W;
  localparam int EDGES    = TOT_W + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic             sdi = 1'b0;
  logic             cnvStart, sclk, headDin, sampleValid, convErr;
  logic [TOT_W-1:0] samples;

  chain_adc_reader #(
    .NUM_DEV(NUM_DEV), .SAMPLE_W(SAMPLE_W), .DIV_HALF(DIV_HALF), .TIMEOUT(TIMEOUT)
  ) i_chain_adc_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdi(sdi), .cnvStart(cnvStart),
    .sclk(sclk), .headDin(headDin), .samples(samples), .sampleValid(sampleValid),
    .convErr(convErr)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cyc = 0;
  int convDly = 0;
  int falls = 0;
  int rises = 0;
  int validCnt = 0;
  int errCnt = 0;
  int lastFallCyc = 0;
  int fallsThisRead = 0;
  logic             sclkPrev = 1'b1;
  logic [TOT_W-1:0] expVec;
  logic [TOT_W-1:0] heldExp = '0;
  logic [SAMPLE_W-1:0] devVal [1:NUM_DEV];
  logic bitQ [$];
  bit   running = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  always @(posedge clk) cyc++;

  // Behavioural chain model: flag after conversion, shift on falling clock.
  always @(posedge cnvStart) begin
    rises++;
    falls = 0;
    chk(sclk === 1'b1 && headDin === 1'b0, "R2",
        $sformatf("at cnvStart rise sclk=%b headDin=%b exp 1/0", sclk, headDin));
    if (convDly >= 0 && sclk === 1'b1 && headDin === 1'b0) begin
      repeat (convDly) @(posedge clk);
      #1;
      bitQ.delete();
      for (int d = NUM_DEV; d >= 1; d--)
        for (int b = SAMPLE_W - 1; b >= 0; b--)
          bitQ.push_back(devVal[d][b]);
      sdi = 1'b1;
    end
  end

  always @(negedge sclk) begin
    if (rstN) begin
      falls++;
      #1;
      if (bitQ.size() > 0) sdi = bitQ.pop_front();
      else sdi = 1'b0;
    end
  end

  always @(negedge cnvStart) begin
    #1;
    sdi = 1'b0;
    bitQ.delete();
  end

  // Per-clock comparison against the behavioural expectations.
  always @(negedge clk) begin
    if (rstN && running) begin
      chk(cnvStart || sclk, "R1", $sformatf("sclk=%b while cnvStart low, exp 1", sclk));
      chk(!(sampleValid && cnvStart), "R7", "sampleValid=1 while cnvStart=1, exp cnvStart 0");
      if (!sampleValid)
        chk(samples === heldExp, "R7",
            $sformatf("samples=%h between strobes, exp held %h", samples, heldExp));
      if (sclkPrev && !sclk) begin
        fallsThisRead++;
        chk(cnvStart === 1'b1, "R3", "sclk fell with cnvStart low");
        if (fallsThisRead > 1)
          chk(cyc - lastFallCyc == 2 * DIV_HALF, "R5",
              $sformatf("fall spacing %0d exp %0d", cyc - lastFallCyc, 2 * DIV_HALF));
        lastFallCyc = cyc;
      end
      if (sampleValid) begin
        validCnt++;
        chk(samples === expVec, "R6", $sformatf("samples=%h exp %h", samples, expVec));
        chk(falls == EDGES, "R4", $sformatf("falling edges %0d exp %0d", falls, EDGES));
        heldExp = samples;
      end
      if (convErr) errCnt++;
    end
    sclkPrev = sclk;
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic setVals(input logic [SAMPLE_W-1:0] a, input logic [SAMPLE_W-1:0] b,
                         input logic [SAMPLE_W-1:0] c);
    devVal[1] = a;
    devVal[2] = b;
    devVal[3] = c;
    for (int d = 1; d <= NUM_DEV; d++) expVec[(d-1)*SAMPLE_W +: SAMPLE_W] = devVal[d];
  endtask

  task automatic runRead(input int dly, input bit pokeStart, input string tag);
    int v0, r0;
    bit seen;
    v0 = validCnt;
    r0 = rises;
    fallsThisRead = 0;
    convDly = dly;
    pulseStart();
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (pokeStart && i == 60) startReq = 1'b1;
      if (pokeStart && i == 61) startReq = 1'b0;
      if (validCnt != v0) seen = 1'b1;
    end
    chk(seen, "R7", $sformatf("%s: sampleValid seen=%b exp 1", tag, seen));
    chk(rises - r0 == 1, "R9", $sformatf("%s: cnvStart rises %0d exp 1", tag, rises - r0));
    repeat (10) @(negedge clk);
    chk(cnvStart === 1'b0 && validCnt - v0 == 1, "R7",
        $sformatf("%s: after read cnv=%b strobes=%0d exp 0/1", tag, cnvStart, validCnt - v0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cnvStart === 1'b0 && sclk === 1'b1 && headDin === 1'b0 &&
        sampleValid === 1'b0 && convErr === 1'b0, "R1",
        $sformatf("in reset cnv=%b sclk=%b din=%b v=%b e=%b exp 0/1/0/0/0",
                  cnvStart, sclk, headDin, sampleValid, convErr));
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    running = 1'b1;
    chk(cnvStart === 1'b0 && sclk === 1'b1 && samples === '0, "R1",
        $sformatf("idle cnv=%b sclk=%b samples=%h exp 0/1/0", cnvStart, sclk, samples));

    setVals(18'h12345, 18'h2ABCD, 18'h0F0F1);
    runRead(6, 1'b0, "mixed");
    setVals(18'h3FFFF, 18'h00000, 18'h3FFFF);
    runRead(0, 1'b0, "ones-zeros");
    setVals(18'h2AAAA, 18'h15555, 18'h20001);
    runRead(12, 1'b1, "alternating with start poke");

    // Timeout: the chain never raises its flag.
    begin
      int e0, v0, f0, t0;
      e0 = errCnt; v0 = validCnt; f0 = fallsThisRead;
      convDly = -1;
      t0 = cyc;
      pulseStart();
      for (int i = 0; i < TIMEOUT + 20 && errCnt == e0; i++) @(negedge clk);
      chk(errCnt - e0 == 1, "R8", $sformatf("convErr pulses %0d exp 1", errCnt - e0));
      chk(cyc - t0 >= TIMEOUT && cyc - t0 <= TIMEOUT + 4, "R8",
          $sformatf("timeout after %0d cycles exp about %0d", cyc - t0, TIMEOUT));
      repeat (5) @(negedge clk);
      chk(cnvStart === 1'b0 && validCnt == v0 && fallsThisRead == f0 && errCnt - e0 == 1, "R8",
          $sformatf("after timeout cnv=%b strobes=%0d falls=%0d exp 0/0/0",
                    cnvStart, validCnt - v0, fallsThisRead - f0));
    end

    setVals(18'h00001, 18'h20000, 18'h1E1E1);
    runRead(3, 1'b0, "after timeout");
    setVals(18'h3C3C3, 18'h0A5A5, 18'h10101);
    runRead(1, 1'b0, "final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule